// File: doc/BRIEF.md
# Two-Dimensional Burst Address Walker

This block turns one rectangular transfer description into a stream of memory burst requests. A description carries a base byte address, a row length, a row count and a row pitch (the distance in bytes from the start of one row to the start of the next). The walker visits every row in order and cuts each row into bursts. Each burst is offered on a valid/ready pair as a start address and a beat count. Only the memory side of a channel needs this walker: a streaming peripheral side has no address and does not use it. The data path and the bus protocol belong to other blocks.

A description is taken over a valid/ready pair while the walker is idle and enabled. The row length and row count arrive in minus-one form, so a one-dimensional transfer has a row count field of zero. With the repeat flag set, the walker goes back to the base address after the last row and walks the same rectangle again, without limit, until enable is dropped. In that case the description is never handed back, and no new one is taken while enable stays high. A one-cycle start pulse marks each accepted description. A one-cycle pass-done pulse marks the end of every complete pass.

The controller has four states:
- `ST_IDLE` waits for a description.
- `ST_ISSUE` offers bursts.
- `ST_ROW_STEP` moves the row base forward by the pitch.
- `ST_RESTART` reloads the base address for a repeat pass.

Its transitions are:
- accept: `ST_IDLE` to `ST_ISSUE`.
- next burst: `ST_ISSUE` stays in `ST_ISSUE`.
- row end: `ST_ISSUE` to `ST_ROW_STEP`.
- row step: `ST_ROW_STEP` to `ST_ISSUE`.
- pass end with repeat: `ST_ISSUE` to `ST_RESTART`.
- restart: `ST_RESTART` to `ST_ISSUE`.
- pass end without repeat, or enable low at a burst handshake: to `ST_IDLE`.
- enable low in either step state: to `ST_IDLE`.

Top module: `tdma_addr_gen`

## Requirements
- R1: `desc_ready` is high exactly when the walker is in `ST_IDLE` and `enable` is high. After reset, `desc_ready`, `burst_valid`, `start_pulse` and `done_pulse` are low while `enable` is low. A description offered while busy waits until the current one completes. `start_pulse` is high for one cycle, in the cycle after each accepted handshake.
- R2: The row length field holds the byte count minus one, and the row count field holds the number of rows minus one.
- R3: Row k (counting from 0) starts at base + k × pitch. Within a row, each burst starts where the previous one ended, and the rows are walked in increasing k.
- R4: A burst carries between 1 and MAX_BEATS (16) beats. `burst_len_m1` is the beat count minus one. Each burst is as long as the remaining row bytes, the 16-beat limit and the 4 KB page allow.
- R5: No burst crosses a 4096-byte address boundary.
- R6: `done_pulse` is high for one cycle, in the cycle after the handshake of the final burst of the final row of each pass.
- R7: With the repeat flag set, the walker starts the next pass at the base address with no new description, and `desc_ready` stays low while enable is high.
- R8: When `enable` is low, an offered burst is held until it is accepted. After that handshake no further burst is offered, and no done pulse appears unless that burst ended a pass.
- R9: While `burst_valid` is high and `burst_ready` is low, `burst_valid`, `burst_addr` and `burst_len_m1` hold their values.
- R10: The base address, the pitch and the row byte count must be multiples of the beat width BEAT_BYTES (4). Every burst address is then beat aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run enable; low stops the walker after the current burst |
| desc_valid | input | 1 | Description offered |
| desc_ready | output | 1 | Description taken this cycle if valid |
| desc_addr | input | ADDR_W | Base byte address |
| desc_xlen_m1 | input | LEN_W | Row length in bytes, minus one |
| desc_ylen_m1 | input | YLEN_W | Row count, minus one |
| desc_stride | input | ADDR_W | Row pitch in bytes |
| desc_cyclic | input | 1 | Repeat the rectangle until disabled |
| burst_valid | output | 1 | Burst request offered |
| burst_ready | input | 1 | Burst request taken |
| burst_addr | output | ADDR_W | Burst start byte address |
| burst_len_m1 | output | $clog2(MAX_BEATS) | Beats in burst, minus one |
| start_pulse | output | 1 | One-cycle pulse after a description is accepted |
| done_pulse | output | 1 | One-cycle pulse after a pass completes |

## Verification
Two functions can fall in the same cycle:
- the handshake of the final burst of a repeating pass, which must raise the pass-done pulse, and
- the fall of enable, which must stop the walker rather than restart it.

The bench provokes this by holding `burst_ready` low until the only burst of a one-burst repeating pass is offered. It then drops `enable` and raises `burst_ready` together. A correct walker gives exactly one done pulse and returns to idle with no further burst. Throughout, a pitch and base sweep that places rows across 4 KB boundaries is run under a stalling ready pattern. Every accepted burst is compared against an arithmetic model of the expected address and length.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_ROW_STEP,
        ST_RESTART
    } agen_state_t;

    typedef enum logic [2:0] {
        WK_HOLD,
        WK_LOAD,
        WK_BURST,
        WK_ROW,
        WK_PASS
    } walk_cmd_t;

endpackage

// File: rtl/tdma_burst_sizer.sv
module tdma_burst_sizer #(
    parameter int ADDR_W     = 32,
    parameter int XB_W       = 13,
    parameter int BEAT_BYTES = 4,
    parameter int MAX_BEATS  = 16,
    parameter int PAGE_BYTES = 4096
) (
    input  logic [ADDR_W-1:0]            cur_addr,
    input  logic [XB_W-1:0]              rem_bytes,
    output logic [$clog2(MAX_BEATS)-1:0] beats_m1,
    output logic [XB_W-1:0]              step_bytes
);
    localparam int BEAT_SH = $clog2(BEAT_BYTES);
    localparam int PAGE_SH = $clog2(PAGE_BYTES);
    localparam int BL_W    = $clog2(MAX_BEATS);
    localparam int CMP_W   = 32;

    logic [PAGE_SH:0]  page_room;
    logic [CMP_W-1:0]  rem_beats;
    logic [CMP_W-1:0]  page_beats;
    logic [CMP_W-1:0]  pick;

    always_comb begin
        page_room  = (PAGE_SH+1)'(PAGE_BYTES) - (PAGE_SH+1)'(cur_addr[PAGE_SH-1:0]);
        page_beats = CMP_W'(page_room >> BEAT_SH);
        rem_beats  = CMP_W'(rem_bytes >> BEAT_SH);
        pick       = CMP_W'(MAX_BEATS);
        if (rem_beats < pick)  pick = rem_beats;
        if (page_beats < pick) pick = page_beats;
        beats_m1   = BL_W'(pick - 1);
        step_bytes = XB_W'(pick << BEAT_SH);
    end

endmodule

// File: rtl/tdma_row_walker.sv
module tdma_row_walker
    import tdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 12,
    parameter int YLEN_W = 8,
    parameter int XB_W   = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  walk_cmd_t         cmd,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic [LEN_W-1:0]  d_xlen_m1,
    input  logic [YLEN_W-1:0] d_ylen_m1,
    input  logic [ADDR_W-1:0] d_stride,
    input  logic              d_cyclic,
    input  logic [XB_W-1:0]   step_bytes,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [XB_W-1:0]   rem_bytes,
    output logic              cyclic,
    output logic              row_end,
    output logic              last_row
);
    logic [ADDR_W-1:0] base_q, stride_q, row_base_q, cur_q;
    logic [XB_W-1:0]   xbytes_q, rem_q;
    logic [YLEN_W-1:0] ylast_q, row_idx_q;
    logic              cyclic_q;
    logic [ADDR_W-1:0] next_row_base;

    assign next_row_base = row_base_q + stride_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q     <= '0;
            stride_q   <= '0;
            row_base_q <= '0;
            cur_q      <= '0;
            xbytes_q   <= '0;
            rem_q      <= '0;
            ylast_q    <= '0;
            row_idx_q  <= '0;
            cyclic_q   <= 1'b0;
        end else begin
            unique case (cmd)
                WK_LOAD: begin
                    base_q     <= d_addr;
                    stride_q   <= d_stride;
                    row_base_q <= d_addr;
                    cur_q      <= d_addr;
                    xbytes_q   <= XB_W'(d_xlen_m1) + 1'b1;
                    rem_q      <= XB_W'(d_xlen_m1) + 1'b1;
                    ylast_q    <= d_ylen_m1;
                    row_idx_q  <= '0;
                    cyclic_q   <= d_cyclic;
                end
                WK_BURST: begin
                    cur_q <= cur_q + ADDR_W'(step_bytes);
                    rem_q <= rem_q - step_bytes;
                end
                WK_ROW: begin
                    row_base_q <= next_row_base;
                    cur_q      <= next_row_base;
                    rem_q      <= xbytes_q;
                    row_idx_q  <= row_idx_q + 1'b1;
                end
                WK_PASS: begin
                    row_base_q <= base_q;
                    cur_q      <= base_q;
                    rem_q      <= xbytes_q;
                    row_idx_q  <= '0;
                end
                default: ;
            endcase
        end
    end

    assign cur_addr  = cur_q;
    assign rem_bytes = rem_q;
    assign cyclic    = cyclic_q;
    assign row_end   = (rem_q <= step_bytes);
    assign last_row  = (row_idx_q == ylast_q);

endmodule

// File: rtl/tdma_addr_gen.sv
module tdma_addr_gen
    import tdma_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 12,
    parameter int YLEN_W     = 8,
    parameter int BEAT_BYTES = 4,
    parameter int MAX_BEATS  = 16,
    parameter int PAGE_BYTES = 4096
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         enable,
    input  logic                         desc_valid,
    output logic                         desc_ready,
    input  logic [ADDR_W-1:0]            desc_addr,
    input  logic [LEN_W-1:0]             desc_xlen_m1,
    input  logic [YLEN_W-1:0]            desc_ylen_m1,
    input  logic [ADDR_W-1:0]            desc_stride,
    input  logic                         desc_cyclic,
    output logic                         burst_valid,
    input  logic                         burst_ready,
    output logic [ADDR_W-1:0]            burst_addr,
    output logic [$clog2(MAX_BEATS)-1:0] burst_len_m1,
    output logic                         start_pulse,
    output logic                         done_pulse
);
    localparam int XB_W    = LEN_W + 1;
    localparam int PAGE_SH = $clog2(PAGE_BYTES);

    agen_state_t       state_q, state_d;
    walk_cmd_t         cmd;
    logic [ADDR_W-1:0] cur_addr;
    logic [XB_W-1:0]   rem_bytes, step_bytes;
    logic              cyc_mode, row_end, last_row;
    logic              accept, pass_end;
    logic              start_q, done_q;

    tdma_row_walker #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .YLEN_W(YLEN_W), .XB_W(XB_W)
    ) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .d_addr     (desc_addr),
        .d_xlen_m1  (desc_xlen_m1),
        .d_ylen_m1  (desc_ylen_m1),
        .d_stride   (desc_stride),
        .d_cyclic   (desc_cyclic),
        .step_bytes (step_bytes),
        .cur_addr   (cur_addr),
        .rem_bytes  (rem_bytes),
        .cyclic     (cyc_mode),
        .row_end    (row_end),
        .last_row   (last_row)
    );

    tdma_burst_sizer #(
        .ADDR_W(ADDR_W), .XB_W(XB_W), .BEAT_BYTES(BEAT_BYTES),
        .MAX_BEATS(MAX_BEATS), .PAGE_BYTES(PAGE_BYTES)
    ) u_sizer (
        .cur_addr   (cur_addr),
        .rem_bytes  (rem_bytes),
        .beats_m1   (burst_len_m1),
        .step_bytes (step_bytes)
    );

    // Next-state and walker command
    always_comb begin
        state_d  = state_q;
        cmd      = WK_HOLD;
        accept   = 1'b0;
        pass_end = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (enable && desc_valid) begin
                    accept  = 1'b1;
                    cmd     = WK_LOAD;
                    state_d = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (burst_ready) begin
                    cmd = WK_BURST;
                    if (row_end && last_row) begin
                        pass_end = 1'b1;
                        state_d  = (cyc_mode && enable) ? ST_RESTART : ST_IDLE;
                    end else if (row_end) begin
                        state_d = enable ? ST_ROW_STEP : ST_IDLE;
                    end else begin
                        state_d = enable ? ST_ISSUE : ST_IDLE;
                    end
                end
            end
            ST_ROW_STEP: begin
                if (enable) begin
                    cmd     = WK_ROW;
                    state_d = ST_ISSUE;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_RESTART: begin
                if (enable) begin
                    cmd     = WK_PASS;
                    state_d = ST_ISSUE;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            start_q <= accept;
            done_q  <= pass_end;
        end
    end

    assign desc_ready  = (state_q == ST_IDLE) && enable;
    assign burst_valid = (state_q == ST_ISSUE);
    assign burst_addr  = cur_addr;
    assign start_pulse = start_q;
    assign done_pulse  = done_q;

    AST_START_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && desc_ready |=> start_pulse); // R1
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ready |-> !burst_valid); // R7
    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid && !burst_ready |=> burst_valid && $stable(burst_addr) && $stable(burst_len_m1)); // R9
    AST_PAGE_FIT: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |-> (32'(burst_addr[PAGE_SH-1:0]) + ((32'(burst_len_m1) + 32'd1) * BEAT_BYTES)) <= PAGE_BYTES); // R5
    AST_BEAT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid |-> (burst_addr % BEAT_BYTES) == 0); // R10
    AST_DESC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && desc_ready |-> (desc_addr % BEAT_BYTES) == 0 && (desc_stride % BEAT_BYTES) == 0
        && ((32'(desc_xlen_m1) + 32'd1) % BEAT_BYTES) == 0); // R10
    AST_STOP_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        burst_valid && burst_ready && !enable |=> !burst_valid); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse); // R6

endmodule

// File: tb/tdma_addr_gen_test.sv
module tdma_addr_gen_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic        desc_valid;
    logic        desc_ready;
    logic [31:0] desc_addr;
    logic [11:0] desc_xlen_m1;
    logic [7:0]  desc_ylen_m1;
    logic [31:0] desc_stride;
    logic        desc_cyclic;
    logic        burst_valid;
    logic        burst_ready;
    logic [31:0] burst_addr;
    logic [3:0]  burst_len_m1;
    logic        start_pulse;
    logic        done_pulse;

    tdma_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_addr(desc_addr), .desc_xlen_m1(desc_xlen_m1),
        .desc_ylen_m1(desc_ylen_m1), .desc_stride(desc_stride),
        .desc_cyclic(desc_cyclic), .burst_valid(burst_valid),
        .burst_ready(burst_ready), .burst_addr(burst_addr),
        .burst_len_m1(burst_len_m1), .start_pulse(start_pulse),
        .done_pulse(done_pulse)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0, rdy_mode = 2;
    int rd = 0, wr = 0, dones = 0, starts = 0;
    bit finished = 0;
    logic [31:0] exp_addr [0:1023];
    logic [3:0]  exp_len  [0:1023];
    bit          exp_last [0:1023];
    bit          exp_done = 0, exp_start = 0, held = 0;
    logic [31:0] held_addr;
    logic [3:0]  held_len;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Ready pattern, applied just after each rising edge
    always begin
        @(posedge clk);
        #1;
        case (rdy_mode)
            0: burst_ready = ((cyc % 4) != 1);
            1: burst_ready = 1'b0;
            default: burst_ready = 1'b1;
        endcase
    end

    // Output monitor, sampled on falling edges
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            cyc++;
            if (done_pulse || exp_done)
                chk(done_pulse == exp_done, "R6 done pulse timing", done_pulse, exp_done);
            if (done_pulse) dones++;
            exp_done = 0;
            if (start_pulse || exp_start)
                chk(start_pulse == exp_start, "R1 start pulse timing", start_pulse, exp_start);
            if (start_pulse) starts++;
            exp_start = desc_valid && desc_ready;
            if (held) begin
                chk(burst_valid == 1'b1, "R9 valid held", burst_valid, 1);
                chk(burst_addr == held_addr && burst_len_m1 == held_len, "R9 request stable", burst_addr, held_addr);
            end
            held = burst_valid && !burst_ready;
            held_addr = burst_addr;
            held_len = burst_len_m1;
            if (burst_valid && burst_ready) begin
                if (rd == wr) begin
                    chk(0, "R8 unexpected burst", burst_addr, 0);
                end else begin
                    chk(burst_addr == exp_addr[rd % 1024], "R3 burst address", burst_addr, exp_addr[rd % 1024]);
                    chk(burst_len_m1 == exp_len[rd % 1024], "R4 burst length", burst_len_m1, exp_len[rd % 1024]);
                    exp_done = exp_last[rd % 1024];
                    rd++;
                end
            end
        end
    end

    task automatic push_one(input logic [31:0] a, input int bm1, input bit last);
        exp_addr[wr % 1024] = a;
        exp_len[wr % 1024]  = 4'(bm1);
        exp_last[wr % 1024] = last;
        wr++;
    endtask

    // Arithmetic model of one pass (R2, R3, R4, R5)
    task automatic push_pass(input longint base, input int xm1, input int ym1, input longint stride);
        for (int r = 0; r <= ym1; r++) begin
            longint a = base + r * stride;
            int rem = xm1 + 1;
            while (rem > 0) begin
                int room = int'((4096 - (a % 4096)) / 4);
                int b = 16;
                if (rem / 4 < b) b = rem / 4;
                if (room < b) b = room;
                push_one(32'(a), b - 1, (r == ym1) && (rem == b * 4));
                a = a + b * 4;
                rem = rem - b * 4;
            end
        end
    endtask

    task automatic submit(input logic [31:0] a, input int xm1, input int ym1, input logic [31:0] s, input bit cy);
        bit acc;
        @(posedge clk); #2;
        desc_addr = a; desc_xlen_m1 = 12'(xm1); desc_ylen_m1 = 8'(ym1);
        desc_stride = s; desc_cyclic = cy; desc_valid = 1'b1;
        do begin
            @(negedge clk);
            acc = desc_ready;
        end while (!acc);
        @(posedge clk); #2;
        desc_valid = 1'b0;
    endtask

    task automatic wait_drain(input string tag);
        int n = 0;
        while ((rd != wr || burst_valid || !desc_ready) && n < 4000) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
        chk(rd == wr, tag, rd, wr);
    endtask

    initial begin
        int d0, s0;
        rst_n = 1'b0; enable = 1'b0; desc_valid = 1'b0; desc_cyclic = 1'b0;
        desc_addr = '0; desc_xlen_m1 = '0; desc_ylen_m1 = '0; desc_stride = '0;
        burst_ready = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk(desc_ready == 0, "R1 reset desc_ready low", desc_ready, 0);
        chk(burst_valid == 0, "R1 reset burst_valid low", burst_valid, 0);
        chk(!start_pulse && !done_pulse, "R1 reset pulses low", {start_pulse, done_pulse}, 0);
        @(posedge clk); #2 enable = 1'b1;
        @(negedge clk);
        chk(desc_ready == 1, "R1 ready when idle and enabled", desc_ready, 1);

        // 1D row, 25 beats: 16 + 9 (R2, R4)
        push_pass(32'h100, 99, 0, 0);
        submit(32'h100, 99, 0, 0, 0);
        wait_drain("R2 1D drain");

        // Page crossing with stalls (R5)
        rdy_mode = 0;
        push_pass(32'hFF0, 63, 0, 0);
        submit(32'hFF0, 63, 0, 0, 0);
        wait_drain("R5 page split drain");

        // Back-to-back 2D descriptions; second waits (R1, R3)
        s0 = starts;
        push_pass(32'h2000, 39, 3, 32'h100);
        push_pass(32'h0F80, 127, 2, 32'h44);
        submit(32'h2000, 39, 3, 32'h100, 0);
        submit(32'h0F80, 127, 2, 32'h44, 0);
        wait_drain("R3 2D pair drain");
        chk(starts - s0 == 2, "R1 one start per description", starts - s0, 2);

        // Sweep over pitch, base and size near page edges
        for (int i = 0; i < 8; i++) begin
            int xm1 = (i * 13 + 1) * 4 - 1;
            int ym1 = i % 3;
            longint st = i * 32'h90 + 32'h100;
            longint bs = 32'hF00 + i * 40;
            push_pass(bs, xm1, ym1, st);
            submit(32'(bs), xm1, ym1, 32'(st), 0);
            wait_drain("R3 sweep drain");
        end

        // Repeat mode: two passes, then disable (R7)
        d0 = dones;
        push_pass(32'h300, 47, 1, 32'h80);
        push_pass(32'h300, 47, 1, 32'h80);
        submit(32'h300, 47, 1, 32'h80, 1);
        begin
            int seen = 0, n = 0;
            while (seen < 2 && n < 2000) begin
                @(posedge clk); #2;
                chk(desc_ready == 0, "R7 no new description while repeating", desc_ready, 0);
                if (done_pulse) seen++;
                n++;
            end
            enable = 1'b0;
        end
        repeat (10) @(negedge clk);
        chk(rd == wr, "R7 exactly two passes", rd, wr);
        chk(burst_valid == 0, "R7 idle after disable", burst_valid, 0);
        chk(dones - d0 == 2, "R6 one done per pass", dones - d0, 2);
        @(posedge clk); #2 enable = 1'b1;

        // Coincidence: final burst of repeating pass taken as enable drops
        d0 = dones;
        rdy_mode = 1;
        push_pass(32'h500, 31, 0, 0);
        submit(32'h500, 31, 0, 0, 1);
        while (!burst_valid) begin @(posedge clk); #2; end
        enable = 1'b0; rdy_mode = 2;
        repeat (12) @(negedge clk);
        chk(rd == wr, "R8 no restart after final burst", rd, wr);
        chk(burst_valid == 0, "R8 idle after coincident stop", burst_valid, 0);
        chk(dones - d0 == 1, "R6 done kept on coincident stop", dones - d0, 1);
        @(posedge clk); #2 enable = 1'b1;

        // Disable mid-row: the offered burst completes, nothing follows
        d0 = dones;
        rdy_mode = 1;
        push_one(32'h800, 15, 0);
        submit(32'h800, 255, 0, 0, 0);
        while (!burst_valid) begin @(posedge clk); #2; end
        enable = 1'b0;
        repeat (3) @(negedge clk);
        chk(burst_valid == 1, "R8 offered burst held", burst_valid, 1);
        chk(burst_addr == 32'h800, "R8 held address", burst_addr, 32'h800);
        rdy_mode = 2;
        repeat (10) @(negedge clk);
        chk(rd == wr, "R8 one burst only", rd, wr);
        chk(burst_valid == 0, "R8 idle after stop", burst_valid, 0);
        chk(dones == d0, "R8 no done on partial pass", dones - d0, 0);
        @(posedge clk); #2 enable = 1'b1;
        @(negedge clk);
        chk(desc_ready == 1, "R1 ready again after stop", desc_ready, 1);

        report();
    end

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual %0d expected %0d", rd, wr);
        report();
    end

endmodule